// File: doc/BRIEF.md
# Unlockable Timing Register Window for a Disk Task-File Port

This block sits between a host and the task-file register port of a disk interface. Each host access is one strobe, read or write, with a register offset and a 16-bit or 8-bit size flag. While nothing special has happened, every access passes straight through to the drive-side task-file port, and read data comes back from there.

A hidden bank of timing and configuration registers can be laid over the same offsets. The host reaches it by a short unlock sequence. It first makes two consecutive 16-bit reads of offset 1, then a byte write of 0x03 to offset 2. Idle cycles between these accesses are allowed. While the window is open, accesses go to the bank and none reach the drive side. A byte write of 0x83 to offset 2 closes the window.

The bank holds a read-cycle and a write-cycle timing byte for each drive, a control byte, a read-only strap byte and a miscellaneous byte. Bit 0 of the miscellaneous byte selects the drive whose timing bytes are being accessed. The control byte decides whether the stored timings are presented to the timing outputs.

Top module: `cfgwin_top`

## Requirements
- R1: After reset the window is closed, `tim_live` is 0, `misc_o` and both timing outputs are zero, all timing bytes are zero, and the control register reads back 0x11 once the window is opened.
- R2: While the window is closed, each host strobe, offset, size and write data appears unchanged on the `tf_*` outputs in the same cycle, and `h_rdata` equals `tf_rdata`.
- R3: Two consecutive 16-bit reads of offset 1 followed by an 8-bit write whose low byte is 0x03 to offset 2 open the window. `win_open` rises in the cycle after that write. The accesses of the sequence are themselves forwarded.
- R4: While the sequence is only partly done, any other access returns the detector to its start, for example a byte read of offset 1, a 16-bit read of another offset, a write to another offset, or a write of a different value. A further 16-bit read of offset 1 after the two reads keeps the sequence armed.
- R5: While the window is open, `tf_rd` and `tf_wr` stay low for every access, including the closing write.
- R6: While the window is open, reads return the addressed register in bits 7:0 of `h_rdata`, with the upper bits zero. The map is: offset 0 is read timing, offset 1 is write timing, offset 3 is control, offset 5 is strap, offset 6 is miscellaneous. Offsets 2, 4 and 7 read 0, and writes to them store nothing.
- R7: Writes to the miscellaneous register store bits 6:0. Bit 7 always reads 0. `misc_o` shows the stored value, and it changes only on a write to offset 6 while the window is open.
- R8: Offsets 0 and 1 read and write the timing bytes of the drive selected by miscellaneous bit 0, so each drive keeps its own pair.
- R9: Writing 0x11 to control sets `tim_live` to 0. Writing 0x95 sets it to 1. Any other value is stored and read back but leaves `tim_live` unchanged. While `tim_live` is 0, `rd_tim_o` and `wr_tim_o` are zero. While it is 1, they show each drive's stored bytes (drive d in bits 8d+7:8d).
- R10: The strap register reads `strap_slow` in bit 0 (0 means the faster 33 MHz bus clock, 1 the 25 MHz one) with the other bits zero. Writes to it have no effect.
- R11: Only an 8-bit write whose low byte is 0x83 to offset 2 closes the window, and `win_open` falls in the next cycle. A 16-bit write of the same value does not close it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| h_rd | input | 1 | Host read strobe, one cycle per access |
| h_wr | input | 1 | Host write strobe, one cycle per access |
| h_ofs | input | 3 | Register offset of the access |
| h_wide | input | 1 | 1 for a 16-bit access, 0 for an 8-bit access |
| h_wdata | input | 16 | Host write data (byte accesses use bits 7:0) |
| h_rdata | output | 16 | Read data back to the host |
| tf_rd | output | 1 | Forwarded read strobe to the task-file port |
| tf_wr | output | 1 | Forwarded write strobe to the task-file port |
| tf_ofs | output | 3 | Forwarded offset |
| tf_wide | output | 1 | Forwarded size flag |
| tf_wdata | output | 16 | Forwarded write data |
| tf_rdata | input | 16 | Read data from the task-file port |
| strap_slow | input | 1 | Bus clock strap, 1 for the slower clock |
| win_open | output | 1 | Configuration window is open |
| tim_live | output | 1 | Stored timings are being applied |
| rd_tim_o | output | 16 | Applied read-cycle timing byte per drive |
| wr_tim_o | output | 16 | Applied write-cycle timing byte per drive |
| misc_o | output | 8 | Miscellaneous register contents |

## Verification
The bench goes after broken unlock sequences. It interrupts the sequence with a byte read of offset 1, a write to another offset or a wrong key value. A detector that only counts matching accesses, with no reset on others, would open the window by mistake. It also adds a third wide read before the key write, which a strict three-step detector would wrongly reject. A wide write of 0x83 checks that only a byte write closes the window. Any forwarded strobe while the window is open, including the closing write, would reach the drive-side registers. Per-drive selection, the masked bit 7 of the miscellaneous byte, the write-protected strap and control values other than 0x11 or 0x95 each show up as a wrong read-back or a wrong timing output.

// File: rtl/cfgwin_pkg.sv
package cfgwin_pkg;

   // sequence detector states
   typedef enum logic [1:0] {
      SQ_IDLE  = 2'd0,
      SQ_ONE   = 2'd1,
      SQ_ARMED = 2'd2,
      SQ_OPEN  = 2'd3
   } seq_state_e;

   // configuration byte width
   localparam int CFG_W = 8;

   // offsets used by the unlock sequence
   localparam int OFS_ARM = 1;
   localparam int OFS_KEY = 2;

   // overlay map while the window is open
   localparam int OFS_RDTIM = 0;
   localparam int OFS_WRTIM = 1;
   localparam int OFS_CTRL  = 3;
   localparam int OFS_STRAP = 5;
   localparam int OFS_MISC  = 6;

   // key values and control codes
   localparam logic [CFG_W-1:0] KEY_OPEN   = 8'h03;
   localparam logic [CFG_W-1:0] KEY_CLOSE  = 8'h83;
   localparam logic [CFG_W-1:0] CTRL_HOLD  = 8'h11;
   localparam logic [CFG_W-1:0] CTRL_APPLY = 8'h95;

   // writable bits of the miscellaneous byte
   localparam logic [CFG_W-1:0] MISC_WR_MASK = 8'h7f;

endpackage

// File: rtl/cfgwin_seq.sv
module cfgwin_seq
   import cfgwin_pkg::*;
#(
   parameter int OFS_W = 3
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             acc_rd,
   input  logic             acc_wr,
   input  logic [OFS_W-1:0] acc_ofs,
   input  logic             acc_wide,
   input  logic [CFG_W-1:0] acc_lo,
   output logic             open_o
);

   seq_state_e st_q, st_d;
   logic any_acc, arm_rd, key_wr, open_wr, close_wr;

   assign any_acc  = acc_rd | acc_wr;
   assign arm_rd   = acc_rd & ~acc_wr & acc_wide & (acc_ofs == OFS_W'(OFS_ARM));
   assign key_wr   = acc_wr & ~acc_rd & ~acc_wide & (acc_ofs == OFS_W'(OFS_KEY));
   assign open_wr  = key_wr & (acc_lo == KEY_OPEN);
   assign close_wr = key_wr & (acc_lo == KEY_CLOSE);

   always_comb begin
      st_d = st_q;
      unique case (st_q)
         SQ_IDLE: begin
            if (arm_rd) st_d = SQ_ONE;
         end
         SQ_ONE: begin
            if (arm_rd)       st_d = SQ_ARMED;
            else if (any_acc) st_d = SQ_IDLE;
         end
         SQ_ARMED: begin
            if (open_wr)      st_d = SQ_OPEN;
            else if (arm_rd)  st_d = SQ_ARMED;
            else if (any_acc) st_d = SQ_IDLE;
         end
         SQ_OPEN: begin
            if (close_wr) st_d = SQ_IDLE;
         end
         default: st_d = SQ_IDLE;
      endcase
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) st_q <= SQ_IDLE;
      else        st_q <= st_d;
   end

   assign open_o = (st_q == SQ_OPEN);

endmodule

// File: rtl/cfgwin_bank.sv
module cfgwin_bank
   import cfgwin_pkg::*;
#(
   parameter int NUM_DRIVES = 2,
   parameter int OFS_W      = 3
) (
   input  logic                        clk,
   input  logic                        rst_n,
   input  logic                        wr_en,
   input  logic [OFS_W-1:0]            ofs,
   input  logic [CFG_W-1:0]            wdata,
   input  logic                        strap_in,
   output logic [CFG_W-1:0]            rdata,
   output logic                        live_o,
   output logic [CFG_W-1:0]            misc_o,
   output logic [NUM_DRIVES*CFG_W-1:0] rd_tim_o,
   output logic [NUM_DRIVES*CFG_W-1:0] wr_tim_o
);

   localparam int SEL_W = (NUM_DRIVES > 1) ? $clog2(NUM_DRIVES) : 1;

   logic [CFG_W-1:0] rt_q [NUM_DRIVES];
   logic [CFG_W-1:0] wt_q [NUM_DRIVES];
   logic [CFG_W-1:0] ctrl_q, misc_q;
   logic             live_q;
   logic [SEL_W-1:0] sel;
   logic [CFG_W-1:0] sel_rt, sel_wt;
   logic             hit_rt, hit_wt, hit_ctrl, hit_misc;

   assign hit_rt   = wr_en & (ofs == OFS_W'(OFS_RDTIM));
   assign hit_wt   = wr_en & (ofs == OFS_W'(OFS_WRTIM));
   assign hit_ctrl = wr_en & (ofs == OFS_W'(OFS_CTRL));
   assign hit_misc = wr_en & (ofs == OFS_W'(OFS_MISC));

   // drive select: one drive needs no index bits
   if (NUM_DRIVES > 1) begin : g_multi
      assign sel    = misc_q[SEL_W-1:0];
      assign sel_rt = rt_q[sel];
      assign sel_wt = wt_q[sel];
   end else begin : g_single
      assign sel    = '0;
      assign sel_rt = rt_q[0];
      assign sel_wt = wt_q[0];
   end

   for (genvar d = 0; d < NUM_DRIVES; d++) begin : g_drv
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) begin
            rt_q[d] <= '0;
            wt_q[d] <= '0;
         end else begin
            if (hit_rt && sel == SEL_W'(d)) rt_q[d] <= wdata;
            if (hit_wt && sel == SEL_W'(d)) wt_q[d] <= wdata;
         end
      end
      assign rd_tim_o[d*CFG_W +: CFG_W] = live_q ? rt_q[d] : '0;
      assign wr_tim_o[d*CFG_W +: CFG_W] = live_q ? wt_q[d] : '0;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         ctrl_q <= CTRL_HOLD;
         live_q <= 1'b0;
         misc_q <= '0;
      end else begin
         if (hit_ctrl) begin
            ctrl_q <= wdata;
            if (wdata == CTRL_HOLD)  live_q <= 1'b0;
            if (wdata == CTRL_APPLY) live_q <= 1'b1;
         end
         if (hit_misc) misc_q <= wdata & MISC_WR_MASK;
      end
   end

   always_comb begin
      rdata = '0;
      if (ofs == OFS_W'(OFS_RDTIM))      rdata = sel_rt;
      else if (ofs == OFS_W'(OFS_WRTIM)) rdata = sel_wt;
      else if (ofs == OFS_W'(OFS_CTRL))  rdata = ctrl_q;
      else if (ofs == OFS_W'(OFS_STRAP)) rdata = {{(CFG_W-1){1'b0}}, strap_in};
      else if (ofs == OFS_W'(OFS_MISC))  rdata = misc_q;
   end

   assign live_o = live_q;
   assign misc_o = misc_q;

endmodule

// File: rtl/cfgwin_route.sv
module cfgwin_route
   import cfgwin_pkg::*;
#(
   parameter int DATA_W = 16,
   parameter int OFS_W  = 3
) (
   input  logic              h_rd,
   input  logic              h_wr,
   input  logic [OFS_W-1:0]  h_ofs,
   input  logic              h_wide,
   input  logic [DATA_W-1:0] h_wdata,
   input  logic              win_open,
   input  logic [CFG_W-1:0]  cfg_rdata,
   input  logic [DATA_W-1:0] tf_rdata,
   output logic              tf_rd,
   output logic              tf_wr,
   output logic [OFS_W-1:0]  tf_ofs,
   output logic              tf_wide,
   output logic [DATA_W-1:0] tf_wdata,
   output logic [DATA_W-1:0] h_rdata,
   output logic              cfg_wr
);

   assign tf_rd    = h_rd & ~win_open;
   assign tf_wr    = h_wr & ~win_open;
   assign tf_ofs   = win_open ? '0 : h_ofs;
   assign tf_wide  = h_wide & ~win_open;
   assign tf_wdata = win_open ? '0 : h_wdata;
   assign cfg_wr   = h_wr & win_open;

   if (DATA_W > CFG_W) begin : g_pad
      assign h_rdata = win_open ? {{(DATA_W-CFG_W){1'b0}}, cfg_rdata} : tf_rdata;
   end else begin : g_nopad
      assign h_rdata = win_open ? cfg_rdata : tf_rdata;
   end

endmodule

// File: rtl/cfgwin_top.sv
module cfgwin_top
   import cfgwin_pkg::*;
#(
   parameter int DATA_W     = 16,
   parameter int OFS_W      = 3,
   parameter int NUM_DRIVES = 2
) (
   input  logic                        clk,
   input  logic                        rst_n,
   input  logic                        h_rd,
   input  logic                        h_wr,
   input  logic [OFS_W-1:0]            h_ofs,
   input  logic                        h_wide,
   input  logic [DATA_W-1:0]           h_wdata,
   output logic [DATA_W-1:0]           h_rdata,
   output logic                        tf_rd,
   output logic                        tf_wr,
   output logic [OFS_W-1:0]            tf_ofs,
   output logic                        tf_wide,
   output logic [DATA_W-1:0]           tf_wdata,
   input  logic [DATA_W-1:0]           tf_rdata,
   input  logic                        strap_slow,
   output logic                        win_open,
   output logic                        tim_live,
   output logic [NUM_DRIVES*CFG_W-1:0] rd_tim_o,
   output logic [NUM_DRIVES*CFG_W-1:0] wr_tim_o,
   output logic [CFG_W-1:0]            misc_o
);

   if (DATA_W != 8 && DATA_W != 16) begin : g_bad_data_w
      $error("cfgwin_top: DATA_W must be 8 or 16");
   end
   if (OFS_W < 3) begin : g_bad_ofs_w
      $error("cfgwin_top: OFS_W must reach offset 6");
   end
   if (NUM_DRIVES < 1 || NUM_DRIVES > 2) begin : g_bad_drives
      $error("cfgwin_top: NUM_DRIVES must be 1 or 2");
   end

   logic [CFG_W-1:0] cfg_rdata;
   logic             cfg_wr;

   cfgwin_seq #(.OFS_W(OFS_W)) seq_i (
      .clk      (clk),
      .rst_n    (rst_n),
      .acc_rd   (h_rd),
      .acc_wr   (h_wr),
      .acc_ofs  (h_ofs),
      .acc_wide (h_wide),
      .acc_lo   (h_wdata[CFG_W-1:0]),
      .open_o   (win_open)
   );

   cfgwin_route #(.DATA_W(DATA_W), .OFS_W(OFS_W)) route_i (
      .h_rd      (h_rd),
      .h_wr      (h_wr),
      .h_ofs     (h_ofs),
      .h_wide    (h_wide),
      .h_wdata   (h_wdata),
      .win_open  (win_open),
      .cfg_rdata (cfg_rdata),
      .tf_rdata  (tf_rdata),
      .tf_rd     (tf_rd),
      .tf_wr     (tf_wr),
      .tf_ofs    (tf_ofs),
      .tf_wide   (tf_wide),
      .tf_wdata  (tf_wdata),
      .h_rdata   (h_rdata),
      .cfg_wr    (cfg_wr)
   );

   cfgwin_bank #(.NUM_DRIVES(NUM_DRIVES), .OFS_W(OFS_W)) bank_i (
      .clk      (clk),
      .rst_n    (rst_n),
      .wr_en    (cfg_wr),
      .ofs      (h_ofs),
      .wdata    (h_wdata[CFG_W-1:0]),
      .strap_in (strap_slow),
      .rdata    (cfg_rdata),
      .live_o   (tim_live),
      .misc_o   (misc_o),
      .rd_tim_o (rd_tim_o),
      .wr_tim_o (wr_tim_o)
   );

endmodule

// File: rtl/cfgwin_chk.sv
module cfgwin_chk
   import cfgwin_pkg::*;
#(
   parameter int DATA_W     = 16,
   parameter int OFS_W      = 3,
   parameter int NUM_DRIVES = 2
) (
   input logic                        clk,
   input logic                        rst_n,
   input logic                        h_rd,
   input logic                        h_wr,
   input logic [OFS_W-1:0]            h_ofs,
   input logic                        h_wide,
   input logic [DATA_W-1:0]           h_wdata,
   input logic [DATA_W-1:0]           h_rdata,
   input logic                        tf_rd,
   input logic                        tf_wr,
   input logic                        strap_slow,
   input logic                        win_open,
   input logic                        tim_live,
   input logic [NUM_DRIVES*CFG_W-1:0] rd_tim_o,
   input logic [NUM_DRIVES*CFG_W-1:0] wr_tim_o,
   input logic [CFG_W-1:0]            misc_o
);

   AST_CLOSED_FWD: assert property (@(posedge clk) disable iff (!rst_n)
      (!win_open && (h_rd || h_wr)) |-> (tf_rd == h_rd && tf_wr == h_wr)); // R2

   AST_OPEN_ENTRY: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(win_open) |-> $past(h_wr && !h_wide && h_ofs == OFS_W'(OFS_KEY)
                                && h_wdata[CFG_W-1:0] == KEY_OPEN)); // R3

   AST_OPEN_NO_FWD: assert property (@(posedge clk) disable iff (!rst_n)
      win_open |-> (!tf_rd && !tf_wr)); // R5

   AST_MISC_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
      !(win_open && h_wr && h_ofs == OFS_W'(OFS_MISC)) |=> $stable(misc_o)); // R7

   AST_SUSPEND_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
      !tim_live |-> (rd_tim_o == '0 && wr_tim_o == '0)); // R9

   AST_STRAP_READ: assert property (@(posedge clk) disable iff (!rst_n)
      (win_open && h_rd && h_ofs == OFS_W'(OFS_STRAP))
      |-> h_rdata == {{(DATA_W-1){1'b0}}, strap_slow}); // R10

   AST_CLOSE_KEY: assert property (@(posedge clk) disable iff (!rst_n)
      (win_open && h_wr && !h_rd && !h_wide && h_ofs == OFS_W'(OFS_KEY)
       && h_wdata[CFG_W-1:0] == KEY_CLOSE) |=> !win_open); // R11

endmodule

bind cfgwin_top cfgwin_chk #(.DATA_W(DATA_W), .OFS_W(OFS_W), .NUM_DRIVES(NUM_DRIVES)) chk_i (.*);

// File: tb/cfgwin_tb.sv
module cfgwin_top_tb_top;
   localparam int CLK_PERIOD = 10;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        h_rd = 1'b0, h_wr = 1'b0, h_wide = 1'b0;
   logic [2:0]  h_ofs = '0;
   logic [15:0] h_wdata = '0, tf_rdata = '0;
   logic        strap_slow = 1'b0;
   logic [15:0] h_rdata, tf_wdata;
   logic        tf_rd, tf_wr, tf_wide, win_open, tim_live;
   logic [2:0]  tf_ofs;
   logic [15:0] rd_tim_o, wr_tim_o;
   logic [7:0]  misc_o;

   int total = 0, bad = 0;
   bit done = 0;

   // bench model of the expected state
   int         m_st = 0; // 0 idle, 1 one read, 2 armed, 3 open
   logic [7:0] m_rt [2];
   logic [7:0] m_wt [2];
   logic [7:0] m_ctrl = 8'h11, m_misc = 8'h00;
   bit         m_live = 0;

   always #(CLK_PERIOD/2) clk = ~clk;

   cfgwin_top dut_i (.*);

   task automatic chk(input bit ok, input string req, input longint act, input longint exp);
      total++;
      if (!ok) begin
         bad++;
         $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
      end
   endtask

   function automatic logic [7:0] m_read(input int ofs);
      case (ofs)
         0: return m_rt[m_misc[0]];
         1: return m_wt[m_misc[0]];
         3: return m_ctrl;
         5: return {7'b0, strap_slow};
         6: return m_misc;
         default: return 8'h00;
      endcase
   endfunction

   function automatic string req_of(input int ofs);
      case (ofs)
         0, 1: return "R8";
         3: return "R9";
         5: return "R10";
         6: return "R7";
         default: return "R6";
      endcase
   endfunction

   task automatic m_apply(input bit wr, input int ofs, input bit wide, input logic [15:0] d);
      bit arm, key;
      if (m_st == 3) begin
         if (wr) begin
            case (ofs)
               0: m_rt[m_misc[0]] = d[7:0];
               1: m_wt[m_misc[0]] = d[7:0];
               3: begin
                  m_ctrl = d[7:0];
                  if (d[7:0] == 8'h11) m_live = 0;
                  if (d[7:0] == 8'h95) m_live = 1;
               end
               6: m_misc = d[7:0] & 8'h7f;
               2: if (!wide && d[7:0] == 8'h83) m_st = 0;
               default: ;
            endcase
         end
      end else begin
         arm = !wr && wide && ofs == 1;
         key = wr && !wide && ofs == 2 && d[7:0] == 8'h03;
         case (m_st)
            0: if (arm) m_st = 1;
            1: m_st = arm ? 2 : 0;
            default: m_st = key ? 3 : (arm ? 2 : 0);
         endcase
      end
   endtask

   task automatic chk_regs(input string req);
      logic [15:0] exp_rt, exp_wt;
      exp_rt = m_live ? {m_rt[1], m_rt[0]} : 16'h0;
      exp_wt = m_live ? {m_wt[1], m_wt[0]} : 16'h0;
      chk(win_open == (m_st == 3), req, win_open, m_st == 3);
      chk(tim_live == m_live, "R9", tim_live, m_live);
      chk(rd_tim_o == exp_rt && wr_tim_o == exp_wt, "R9", {rd_tim_o, wr_tim_o}, {exp_rt, exp_wt});
      chk(misc_o == m_misc, "R7", misc_o, m_misc);
   endtask

   // one host access; returns read data seen by the host
   task automatic acc(input bit wr, input int ofs, input bit wide, input logic [15:0] d,
                      output logic [15:0] rd_seen);
      @(negedge clk);
      h_rd = !wr; h_wr = wr; h_ofs = 3'(ofs); h_wide = wide; h_wdata = d;
      tf_rdata = 16'($urandom);
      #1;
      rd_seen = h_rdata;
      if (m_st != 3) begin
         chk(tf_rd == !wr && tf_wr == wr && tf_ofs == 3'(ofs) && tf_wide == wide && tf_wdata == d,
             "R2", {tf_rd, tf_wr, tf_ofs, tf_wide, tf_wdata}, {!wr, wr, 3'(ofs), wide, d});
         if (!wr) chk(h_rdata == tf_rdata, "R2", h_rdata, tf_rdata);
      end else begin
         chk(!tf_rd && !tf_wr, "R5", {tf_rd, tf_wr}, 0);
         if (!wr) chk(h_rdata == {8'h00, m_read(ofs)}, req_of(ofs), h_rdata, {8'h00, m_read(ofs)});
      end
      @(posedge clk);
      #1;
      h_rd = 0; h_wr = 0;
      m_apply(wr, ofs, wide, d);
      chk_regs("R3");
   endtask

   task automatic rd(input int ofs, input bit wide, output logic [15:0] q);
      acc(0, ofs, wide, 16'h0, q);
   endtask

   task automatic wr(input int ofs, input bit wide, input logic [15:0] d);
      logic [15:0] q;
      acc(1, ofs, wide, d, q);
   endtask

   task automatic unlock();
      logic [15:0] q;
      rd(1, 1, q); rd(1, 1, q); wr(2, 0, 16'h0003);
   endtask

   initial begin
      repeat (200000) @(posedge clk);
      if (!done) begin
         total++; bad++;
         $display("FAIL watchdog expired");
         $display("  test done: total=%0d bad=%0d", total, bad);
         $finish;
      end
   end

   initial begin
      logic [15:0] q;
      m_rt[0] = 0; m_rt[1] = 0; m_wt[0] = 0; m_wt[1] = 0;
      void'($urandom(32'd4242));
      repeat (3) @(posedge clk);
      @(negedge clk) rst_n = 1;
      #1;
      // R1 reset state
      chk(win_open == 0 && tim_live == 0, "R1", {win_open, tim_live}, 0);
      chk(misc_o == 0 && rd_tim_o == 0 && wr_tim_o == 0, "R1", {misc_o, rd_tim_o, wr_tim_o}, 0);

      // R3 open, R1 control reset value
      unlock();
      chk(win_open == 1, "R3", win_open, 1);
      rd(3, 0, q);
      chk(q == 16'h0011, "R1", q, 16'h0011);
      rd(0, 1, q);
      chk(q == 16'h0000, "R1", q, 0);

      // R8 per-drive timing
      wr(0, 0, 16'h005a); wr(1, 0, 16'h0021);
      wr(6, 0, 16'h0001);
      wr(0, 0, 16'h003c); wr(1, 0, 16'h0047);
      wr(6, 0, 16'h0000);
      rd(0, 0, q);
      chk(q == 16'h005a, "R8", q, 16'h005a);
      wr(6, 0, 16'h0001);
      rd(1, 0, q);
      chk(q == 16'h0047, "R8", q, 16'h0047);

      // R7 bit 7 masked
      wr(6, 0, 16'h00ff);
      rd(6, 0, q);
      chk(q == 16'h007f, "R7", q, 16'h007f);

      // R10 strap read-only
      strap_slow = 1;
      wr(5, 0, 16'h00fe);
      rd(5, 0, q);
      chk(q == 16'h0001, "R10", q, 1);
      strap_slow = 0;
      rd(5, 0, q);
      chk(q == 16'h0000, "R10", q, 0);

      // R9 apply, other, suspend
      wr(3, 0, 16'h0095);
      chk(tim_live == 1 && rd_tim_o == 16'h3c5a && wr_tim_o == 16'h4721, "R9",
          {tim_live, rd_tim_o, wr_tim_o}, {1'b1, 16'h3c5a, 16'h4721});
      wr(3, 0, 16'h0042);
      rd(3, 0, q);
      chk(tim_live == 1 && q == 16'h0042, "R9", {tim_live, q}, {1'b1, 16'h0042});
      wr(3, 0, 16'h0011);
      chk(tim_live == 0 && rd_tim_o == 0, "R9", {tim_live, rd_tim_o}, 0);

      // R6 unmapped offsets
      wr(4, 0, 16'h00aa); wr(7, 0, 16'h00bb);
      rd(4, 0, q);
      chk(q == 16'h0000, "R6", q, 0);
      rd(7, 1, q);
      chk(q == 16'h0000, "R6", q, 0);

      // R11 close only by byte write
      wr(2, 1, 16'h0083);
      chk(win_open == 1, "R11", win_open, 1);
      wr(2, 0, 16'h0083);
      chk(win_open == 0, "R11", win_open, 0);

      // R4 aborts
      rd(1, 1, q); rd(1, 0, q); rd(1, 1, q); wr(2, 0, 16'h0003);
      chk(win_open == 0, "R4", win_open, 0);
      rd(1, 1, q); rd(1, 1, q); wr(3, 0, 16'h0003); wr(2, 0, 16'h0003);
      chk(win_open == 0, "R4", win_open, 0);
      rd(1, 1, q); rd(1, 1, q); wr(2, 0, 16'h0004); wr(2, 0, 16'h0003);
      chk(win_open == 0, "R4", win_open, 0);
      rd(1, 1, q); rd(1, 1, q); rd(1, 1, q); wr(2, 0, 16'h0003);
      chk(win_open == 1, "R4", win_open, 1);
      wr(2, 0, 16'h0083);

      // random mix
      for (int n = 0; n < 4000; n++) begin
         int kind;
         int ofs;
         bit w, wide;
         logic [15:0] d;
         kind = int'($urandom_range(0, 9));
         ofs = int'($urandom_range(0, 7));
         wide = 1'($urandom);
         w = 1'($urandom);
         d = 16'($urandom);
         case ($urandom_range(0, 3))
            0: d[7:0] = 8'h03;
            1: d[7:0] = 8'h83;
            2: d[7:0] = $urandom_range(0, 1) ? 8'h95 : 8'h11;
            default: ;
         endcase
         if (kind < 4) begin w = 0; ofs = 1; wide = (kind != 0); end
         else if (kind < 6) begin w = 1; ofs = 2; wide = (kind == 5) && $urandom_range(0, 3) == 0; end
         if (n % 97 == 0) strap_slow = 1'($urandom);
         acc(w, ofs, wide, d, d);
      end

      done = 1;
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
   end

endmodule